// File: doc/BRIEF.md
# SCSI Arbitration and Selection Sequencer

This block acts for a host initiator on an 8-bit SCSI bus. The host loads a one-hot initiator ID and a combined initiator-plus-target byte into the block. A single write to the start port then makes the block wait for a free bus, arbitrate, and, after a win, select the target. The whole sequence runs without further host action. The block also answers reselection by a target and records the reselecting target's ID.

Bus events are gathered into a six-bit interrupt condition register. A separate mask is applied only where the conditions are combined into the active-low interrupt line, so the raw conditions can always be read back. The read view of that register also shows the reselection step counter and the arbitration/selection step counter, for diagnostics. Bus timing is counted in clocks and set by the parameters `FREE_CLKS` (bus-free wait), `ARB_CLKS` (arbitration delay) and `SEL_TMO` (selection timeout).

Bus signals are open-collector in intent. Each `_o` output set to 1 means the block pulls that line to its asserted level. Each `_i` input is the resolved line, with 1 meaning asserted.

Top module: `scsi_arbsel`

## Requirements
- R1: After reset the block drives no bus line and `irq_n` is 1. The conditions, mask and both step counters read 0. The initiator ID reads 0x80, in the low byte of address 1.
- R2: A write to address 2 from idle starts the sequence. BSY and the ID register's bit on the data lines are driven only after `FREE_CLKS` consecutive clocks with BSY and SEL both negated.
- R3: If no data bit above the block's own ID bit is asserted after `ARB_CLKS` clocks of arbitration, the block has won. Status bit 0 (won) then reads 1 and condition bit 0 (arbitration complete) sets.
- R4: If a higher ID bit is seen, the block releases BSY and the data lines, and status bit 0 reads 0. It retries once the bus has again been free for `FREE_CLKS` clocks.
- R5: After a win the block asserts SEL while still holding BSY. It then drives the address-1 select byte on the data lines, releases BSY and keeps SEL. ATN is driven when bit 1 of the last write to address 3 was 1.
- R6: If BSY returns within `SEL_TMO` clocks, the block releases SEL and the data lines. Status bit 1 (connected) then reads 1, condition bit 1 (selection complete) sets, and the arbitration step counter reads 5.
- R7: If BSY does not return within `SEL_TMO` clocks, the block releases SEL, ATN and the data lines and returns to step 0. Condition bit 1 stays 0 and the connected flag stays 0.
- R8: A write to address 3 with bit 0 set drops BSY, SEL and ATN at once. It also clears the connected flag and both step counters.
- R9: From idle, the block sees SEL and I/O asserted, BSY negated and its own ID bit on the data lines. It then asserts BSY, and the reselection counter reads 1. When SEL drops, it releases BSY, sets connected and sets condition bit 2, and the counter reads 2. A read of address 5 returns the data byte that was seen without the block's own bit.
- R10: Condition bit 3 sets on a rising REQ while MSG is asserted. Bit 4 sets when the bus leaves a data phase (BSY with MSG and C/D negated) for any other state. Bit 5 sets on a rising RST, which also releases all lines.
- R11: The mask is written at address 4, bits 5:0, where 1 means masked. A masked condition still reads as set at address 4. `irq_n` is 0 exactly when some condition is set and unmasked, and several conditions may be set together.
- R12: A read of address 5 clears condition bits 0 and 1 only. A write to address 6 clears every condition bit written as 1. A condition that sets in the same clock as a clear remains set.
- R13: Status bit 2 (new request) sets on each rising REQ. It is cleared by a read of address 0, so a second read returns 0.
- R14: The address-4 read places the conditions in bits 5:0, the reselection counter in bits 9:8 and the arbitration/selection counter in bits 13:10. That counter reads 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (for read side effects) |
| addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 16 | Host read data for `addr` |
| irq_n | output | 1 | Active-low combined interrupt |
| bsy_i | input | 1 | Resolved BSY line |
| sel_i | input | 1 | Resolved SEL line |
| rst_i | input | 1 | Resolved RST line |
| req_i | input | 1 | Resolved REQ line |
| msg_i | input | 1 | Resolved MSG line |
| cd_i | input | 1 | Resolved C/D line |
| io_i | input | 1 | Resolved I/O line |
| db_i | input | 8 | Resolved data lines |
| bsy_o | output | 1 | Drive BSY |
| sel_o | output | 1 | Drive SEL |
| atn_o | output | 1 | Drive ATN |
| db_o | output | 8 | Drive data lines |

## Verification
The main overlap is between a condition being raised and the host clearing it. A bus reset edge can arrive in the same clock as a write-one-to-clear of that bit, and a utility read can land near an arbitration completion. The bench provokes the first case by driving RST and the clearing write on the same clock. It then checks that the condition still reads set, and that a later write on its own does clear it. A second overlap is between arbitration and a competing initiator. Random trials place a competitor above or below the block's ID on the same clock that arbitration begins, and the outcome is judged from the won flag and the lines the block releases.

// File: rtl/scsi_arbsel.sv
module scsi_arbsel #(
  parameter int FREE_CLKS = 4,
  parameter int ARB_CLKS  = 6,
  parameter int SEL_TMO   = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [15:0] rdata,
  output logic        irq_n,
  input  logic        bsy_i,
  input  logic        sel_i,
  input  logic        rst_i,
  input  logic        req_i,
  input  logic        msg_i,
  input  logic        cd_i,
  input  logic        io_i,
  input  logic [7:0]  db_i,
  output logic        bsy_o,
  output logic        sel_o,
  output logic        atn_o,
  output logic [7:0]  db_o
);
  localparam int CM1 = (ARB_CLKS > FREE_CLKS) ? ARB_CLKS : FREE_CLKS;
  localparam int CMAX = (SEL_TMO > CM1) ? SEL_TMO : CM1;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] FREE_END = CW'(FREE_CLKS - 1);
  localparam logic [CW-1:0] ARB_END  = CW'(ARB_CLKS - 1);
  localparam logic [CW-1:0] SEL_END  = CW'(SEL_TMO - 1);
  localparam logic [3:0] S_IDLE = 4'd0, S_FREE = 4'd1, S_ARB = 4'd2,
                         S_SELA = 4'd3, S_SEL = 4'd4, S_CONN = 4'd5;

  logic [7:0]    id_reg, sel_reg, resel_id;
  logic [3:0]    st;
  logic [1:0]    rs;
  logic [CW-1:0] cnt;
  logic          won, conn, atn_en, new_req, req_q, rst_q, dph_q;
  logic [5:0]    cond, mask, set_v, clr_v;

  wire wr_id  = wr_en && addr == 3'd0;
  wire wr_sel = wr_en && addr == 3'd1;
  wire wr_arb = wr_en && addr == 3'd2;
  wire wr_ctl = wr_en && addr == 3'd3;
  wire wr_msk = wr_en && addr == 3'd4;
  wire wr_w1c = wr_en && addr == 3'd6;
  wire rd_st  = rd_en && addr == 3'd0;
  wire rd_utl = rd_en && addr == 3'd5;

  wire clr      = wr_ctl && wdata[0];
  wire abort    = clr || rst_i;
  wire bus_free = !bsy_i && !sel_i;
  wire [7:0] higher = db_i & ~(id_reg | (id_reg - 8'd1));
  wire resel_seen = (st == S_IDLE || st == S_FREE) && rs == 2'd0 && sel_i && io_i
                    && !bsy_i && |(db_i & id_reg);
  wire win        = !abort && st == S_ARB && cnt == ARB_END && higher == 8'd0;
  wire sel_ok     = !abort && st == S_SEL && bsy_i;
  wire resel_done = !abort && rs == 2'd1 && !sel_i;
  wire req_rise   = req_i && !req_q;
  wire dph        = bsy_i && !msg_i && !cd_i;

  assign set_v = {rst_i && !rst_q, dph_q && !dph, req_rise && msg_i, resel_done, sel_ok, win};
  assign clr_v = (wr_w1c ? wdata[5:0] : 6'd0) | (rd_utl ? 6'b000011 : 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rs <= 2'd0; cnt <= '0; won <= 1'b0; conn <= 1'b0; resel_id <= 8'd0;
    end else if (abort) begin
      st <= S_IDLE; rs <= 2'd0; cnt <= '0; conn <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!resel_seen && wr_arb && rs == 2'd0) begin
          st <= S_FREE; cnt <= '0; won <= 1'b0;
        end
        S_FREE: begin
          if (resel_seen) st <= S_IDLE;
          else if (!bus_free) cnt <= '0;
          else if (cnt == FREE_END) begin st <= S_ARB; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_ARB: begin
          if (cnt == ARB_END) begin
            cnt <= '0;
            if (higher == 8'd0) begin st <= S_SELA; won <= 1'b1; end
            else st <= S_FREE;
          end else cnt <= cnt + 1'b1;
        end
        S_SELA: begin st <= S_SEL; cnt <= '0; end
        S_SEL: begin
          if (bsy_i) begin st <= S_CONN; conn <= 1'b1; end
          else if (cnt == SEL_END) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        S_CONN: ;
        default: st <= S_IDLE;
      endcase
      case (rs)
        2'd0: if (resel_seen) begin rs <= 2'd1; resel_id <= db_i & ~id_reg; end
        2'd1: if (!sel_i) begin rs <= 2'd2; conn <= 1'b1; end
        2'd2: ;
        default: rs <= 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_reg <= 8'h80; sel_reg <= 8'h00; atn_en <= 1'b0; mask <= 6'd0; cond <= 6'd0;
      new_req <= 1'b0; req_q <= 1'b0; rst_q <= 1'b0; dph_q <= 1'b0;
    end else begin
      if (wr_id)  id_reg  <= wdata;
      if (wr_sel) sel_reg <= wdata;
      if (clr) atn_en <= 1'b0;
      else if (wr_ctl) atn_en <= wdata[1];
      if (wr_msk) mask <= wdata[5:0];
      cond    <= (cond & ~clr_v) | set_v;
      new_req <= req_rise || (new_req && !rd_st);
      req_q   <= req_i;
      rst_q   <= rst_i;
      dph_q   <= dph;
    end
  end

  assign bsy_o = st == S_ARB || st == S_SELA || rs == 2'd1;
  assign sel_o = st == S_SELA || st == S_SEL;
  assign atn_o = atn_en && (st == S_SELA || st == S_SEL || st == S_CONN);
  assign db_o  = (st == S_ARB) ? id_reg : (st == S_SELA || st == S_SEL) ? sel_reg : 8'h00;
  assign irq_n = ~|(cond & ~mask);

  always_comb begin
    case (addr)
      3'd0:    rdata = {8'h00, bsy_i, msg_i, cd_i, io_i, req_i, new_req, conn, won};
      3'd1:    rdata = {sel_reg, id_reg};
      3'd4:    rdata = {2'b00, st, rs, 2'b00, cond};
      3'd5:    rdata = {8'h00, resel_id};
      3'd6:    rdata = {10'd0, mask};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/scsi_arbsel_chk.sv
module scsi_arbsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       bsy_o,
  input logic       sel_o,
  input logic       atn_o,
  input logic [7:0] db_o,
  input logic       rst_i,
  input logic       req_i,
  input logic [5:0] cond,
  input logic       won,
  input logic       new_req
);
  // R5
  sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> bsy_o && won);

  // R8
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata[0]) |=> !bsy_o && !sel_o && !atn_o);

  // R10
  bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_i |=> !bsy_o && !sel_o && !atn_o);

  // R3
  arb_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond[0]) |-> won);

  // R2
  arb_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy_o && !sel_o && db_o != 8'h00) |-> $countones(db_o) == 1);

  // R13
  new_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !$past(req_i)) |=> new_req);
endmodule

bind scsi_arbsel scsi_arbsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .bsy_o(bsy_o), .sel_o(sel_o), .atn_o(atn_o), .db_o(db_o), .rst_i(rst_i),
  .req_i(req_i), .cond(cond), .won(won), .new_req(new_req)
);

// File: tb/sim_scsi_arbsel.sv
module sim_scsi_arbsel;
  localparam int FREE_CLKS = 4;
  localparam int ARB_CLKS  = 6;
  localparam int SEL_TMO   = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [15:0] rdata;
  logic irq_n, u_bsy, u_sel, u_atn;
  logic [7:0] u_db;
  logic srst = 1'b0, req = 1'b0, msg = 1'b0, cd = 1'b0, io = 1'b0;
  logic c_bsy = 1'b0, r_bsy = 1'b0, r_sel = 1'b0, t_bsy = 1'b0, t_resp = 1'b0;
  logic [7:0] c_db = 8'd0, r_db = 8'd0, t_id = 8'd0;
  int t_cnt = 0;
  int checks = 0, failures = 0;

  wire bsy_bus = u_bsy | c_bsy | r_bsy | t_bsy;
  wire sel_bus = u_sel | r_sel;
  wire [7:0] db_bus = u_db | c_db | r_db;

  always #2 clk = ~clk;

  scsi_arbsel #(.FREE_CLKS(FREE_CLKS), .ARB_CLKS(ARB_CLKS), .SEL_TMO(SEL_TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n), .bsy_i(bsy_bus), .sel_i(sel_bus), .rst_i(srst),
    .req_i(req), .msg_i(msg), .cd_i(cd), .io_i(io), .db_i(db_bus),
    .bsy_o(u_bsy), .sel_o(u_sel), .atn_o(u_atn), .db_o(u_db));

  always @(posedge clk) begin
    if (!t_resp) begin t_bsy <= 1'b0; t_cnt <= 0; end
    else if (!t_bsy && sel_bus && !u_bsy && (db_bus & t_id) != 8'd0) begin
      if (t_cnt == 2) t_bsy <= 1'b1;
      t_cnt <= t_cnt + 1;
    end
  end

  function automatic logic [7:0] oh(input int n);
    return 8'(1) << n;
  endfunction

  function automatic bit loses(input int own, input int comp);
    return comp > own;
  endfunction

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trial(input int own, input int tgt, input int comp, input bit resp, input bit atn);
    logic [15:0] d;
    logic [7:0] sb;
    int k;
    sb = oh(own) | oh(tgt);
    wr(3'd6, 8'h3f);
    wr(3'd0, oh(own));
    wr(3'd1, sb);
    wr(3'd3, {6'd0, atn, 1'b0});
    t_id = oh(tgt); t_resp = resp;
    wr(3'd2, 8'h01);
    idle(FREE_CLKS - 1);
    chk(u_bsy == 1'b0, "R2 early", int'(u_bsy), 0);
    idle(1);
    chk(u_bsy == 1'b1 && u_db == oh(own), "R2 arb id", int'(u_db), int'(oh(own)));
    if (comp >= 0) begin c_bsy = 1'b1; c_db = oh(comp); end
    if (comp >= 0 && loses(own, comp)) begin
      idle(ARB_CLKS + 2);
      chk(!u_bsy && !u_sel && u_db == 8'd0, "R4 release", int'({u_bsy, u_sel, u_db}), 0);
      rd(3'd0, d);
      chk(d[0] == 1'b0, "R4 won flag", int'(d[0]), 0);
      idle(3);
      c_bsy = 1'b0; c_db = 8'd0;
    end
    k = 0;
    while (!u_sel && k < 200) begin @(negedge clk); k++; end
    chk(u_sel && u_bsy, "R3 R5 win then sel", int'({u_sel, u_bsy}), 3);
    c_bsy = 1'b0; c_db = 8'd0;
    @(negedge clk);
    chk(u_sel && !u_bsy && u_db == sb && u_atn == atn, "R5 select drive",
        int'({u_sel, u_bsy, u_atn, u_db}), int'({1'b1, 1'b0, atn, sb}));
    if (resp) begin
      idle(8);
      chk(!u_sel && u_db == 8'd0 && u_atn == atn, "R6 lines", int'({u_sel, u_atn, u_db}), int'({1'b0, atn, 8'd0}));
      rd(3'd0, d);
      chk(d[1:0] == 2'b11, "R6 R3 status", int'(d[1:0]), 3);
      rd(3'd4, d);
      chk(d[1:0] == 2'b11 && d[13:10] == 4'd5, "R6 R14 cond/step", int'(d), 'h1403);
    end else begin
      idle(SEL_TMO + 4);
      chk(!u_sel && !u_atn && u_db == 8'd0, "R7 release", int'({u_sel, u_atn, u_db}), 0);
      rd(3'd0, d);
      chk(d[1:0] == 2'b01, "R7 status", int'(d[1:0]), 1);
      rd(3'd4, d);
      chk(d[1:0] == 2'b01 && d[13:10] == 4'd0, "R7 R14 cond/step", int'(d), 1);
    end
    rd(3'd5, d);
    rd(3'd4, d);
    chk(d[1:0] == 2'b00, "R12 utility clear", int'(d[1:0]), 0);
    wr(3'd3, 8'h01);
    chk(!u_bsy && !u_sel && !u_atn, "R8 lines", int'({u_bsy, u_sel, u_atn}), 0);
    t_resp = 1'b0;
    rd(3'd0, d);
    chk(d[1] == 1'b0, "R8 connected", int'(d[1]), 0);
    rd(3'd4, d);
    chk(d[13:8] == 6'd0, "R8 R14 steps", int'(d[13:8]), 0);
    idle(3);
  endtask

  initial begin
    #(4 * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int own, tgt, comp;
    void'($urandom(32'd20240607));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1
    chk(!u_bsy && !u_sel && !u_atn && u_db == 8'd0 && irq_n, "R1 lines",
        int'({u_bsy, u_sel, u_atn, u_db, irq_n}), 1);
    rd(3'd4, d); chk(d == 16'h0000, "R1 cond/steps", int'(d), 0);
    rd(3'd6, d); chk(d == 16'h0000, "R1 mask", int'(d), 0);
    rd(3'd1, d); chk(d[7:0] == 8'h80, "R1 default id", int'(d[7:0]), 'h80);

    // R9 reselection by target 2
    @(negedge clk); r_sel = 1'b1; io = 1'b1; r_db = 8'h84;
    @(negedge clk);
    chk(u_bsy == 1'b1, "R9 answer bsy", int'(u_bsy), 1);
    rd(3'd4, d); chk(d[9:8] == 2'd1, "R9 step 1", int'(d[9:8]), 1);
    @(negedge clk); r_bsy = 1'b1; r_sel = 1'b0; r_db = 8'h00;
    @(negedge clk);
    chk(u_bsy == 1'b0, "R9 release bsy", int'(u_bsy), 0);
    rd(3'd0, d); chk(d[1] == 1'b1, "R9 connected", int'(d[1]), 1);
    rd(3'd4, d); chk(d[2] == 1'b1 && d[9:8] == 2'd2, "R9 cond/step", int'(d[9:0]), 'h204);
    rd(3'd5, d); chk(d[7:0] == 8'h04, "R9 target id", int'(d[7:0]), 4);
    wr(3'd3, 8'h01);
    r_bsy = 1'b0; io = 1'b0;
    idle(2);

    // R10 R11 R13 phase events
    wr(3'd6, 8'h3f);
    @(negedge clk); r_bsy = 1'b1;
    idle(2);
    cd = 1'b1;
    idle(2);
    msg = 1'b1; req = 1'b1;
    idle(2);
    req = 1'b0;
    rd(3'd4, d); chk(d[4:3] == 2'b11, "R10 msg and odp", int'(d[5:0]), 'h18);
    chk(irq_n == 1'b0, "R11 irq", int'(irq_n), 0);
    rd(3'd0, d); chk(d[2] == 1'b1, "R13 new req", int'(d[2]), 1);
    rd(3'd0, d); chk(d[2] == 1'b0, "R13 cleared", int'(d[2]), 0);
    wr(3'd4, 8'h18);
    @(negedge clk);
    chk(irq_n == 1'b1, "R11 masked", int'(irq_n), 1);
    rd(3'd4, d); chk(d[4:3] == 2'b11, "R11 raw kept", int'(d[4:3]), 3);
    wr(3'd4, 8'h08);
    chk(irq_n == 1'b0, "R11 partial mask", int'(irq_n), 0);
    wr(3'd6, 8'h18);
    rd(3'd4, d); chk(d[5:0] == 6'd0, "R12 w1c", int'(d[5:0]), 0);
    chk(irq_n == 1'b1, "R11 clear irq", int'(irq_n), 1);
    wr(3'd4, 8'h00);
    r_bsy = 1'b0; msg = 1'b0; cd = 1'b0;
    idle(2);
    wr(3'd6, 8'h3f);

    // R10 bus reset, R12 set wins over clear
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    rd(3'd4, d); chk(d[5] == 1'b1, "R10 bus reset", int'(d[5]), 1);
    @(negedge clk); srst = 1'b1; wr_en = 1'b1; addr = 3'd6; wdata = 8'h20;
    @(negedge clk); srst = 1'b0; wr_en = 1'b0;
    rd(3'd4, d); chk(d[5] == 1'b1, "R12 set wins", int'(d[5]), 1);
    wr(3'd6, 8'h20);
    rd(3'd4, d); chk(d[5] == 1'b0, "R12 clear alone", int'(d[5]), 0);

    // directed arbitration cases
    trial(3, 0, 6, 1'b1, 1'b1);
    trial(6, 1, 2, 1'b1, 1'b0);
    trial(7, 0, -1, 1'b0, 1'b1);
    trial(0, 5, 4, 1'b0, 1'b0);

    for (int i = 0; i < 24; i++) begin
      own = int'($urandom_range(7, 0));
      tgt = (own + 1 + int'($urandom_range(6, 0))) % 8;
      comp = -1;
      if ($urandom_range(2, 0) != 0) begin
        comp = int'($urandom_range(7, 0));
        if (comp == own || comp == tgt) comp = -1;
      end
      trial(own, tgt, comp, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule